// File: doc/BRIEF.md
# Peripheral DMA Request Agent

This block sits on the peripheral side of a DMA link. Peripheral logic raises level-sensitive wishes for a single-level or burst-level transfer, with an optional final-transfer marker. The agent turns these into requests toward the DMA controller over a valid/ready request channel. It then accepts acknowledgements from the controller on a second valid/ready channel. Only one data request is outstanding at a time. After a data request is accepted, the agent stays quiet until the controller acknowledges it.

The controller can also ask the peripheral to flush by sending a flush code on the acknowledge channel. The agent records this in a pending-flush flag. The next request it issues is a flush acknowledgement, which goes ahead of any data wish. A flush acknowledgement needs no separate acknowledgement from the controller: its acceptance alone clears the flag. The request channel obeys strict stability rules, so a request cannot be withdrawn or altered once it has been presented.

Top module: `pdma_req_agent`

## Requirements
- R1: While reset is asserted, rq_valid_o is 0, rq_kind_o is 2'b00, rq_last_o is 0 and ak_ready_o is 1.
- R2: rq_valid_o rises only when the agent is idle and a flush is pending or a data wish is present. It falls only after a clock edge at which rq_ready_i was 1.
- R3: While rq_valid_o is 1 and rq_ready_i is 0, the next cycle keeps rq_valid_o at 1 and keeps rq_kind_o and rq_last_o unchanged.
- R4: rq_kind_o is 2'b00 for a single-level request, 2'b01 for a burst-level request and 2'b10 for a flush acknowledgement. The code 2'b11 never appears while rq_valid_o is 1.
- R5: For a data request, rq_last_o equals pr_last_i as sampled at the edge that issued the request. For a flush acknowledgement it is 0.
- R6: After a data request is accepted (rq_valid_o and rq_ready_i both 1 at an edge), no new request is presented until an acknowledge handshake (ak_valid_i and ak_ready_o both 1) carries code 2'b00 or 2'b01.
- R7: An acknowledge handshake with code 2'b10 marks a flush as pending. The next request issued is then a flush acknowledgement (2'b10), even when data wishes are present.
- R8: When pr_burst_i and pr_single_i are both high at issue time, a burst-level request is issued.
- R9: ak_ready_o is 1 while the agent waits for a data acknowledgement or when no flush is pending, and 0 otherwise.
- R10: Acceptance of a flush acknowledgement clears the pending flag and returns the agent to idle without waiting on the acknowledge channel. An acknowledge handshake with code 2'b11, or with a data code while not waiting, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| pr_single_i | input | 1 | Peripheral wants a single-level transfer |
| pr_burst_i | input | 1 | Peripheral wants a burst-level transfer |
| pr_last_i | input | 1 | The wished transfer is the final one |
| rq_valid_o | output | 1 | Request channel valid |
| rq_kind_o | output | 2 | Request type code |
| rq_last_o | output | 1 | Final-transfer marker of the request |
| rq_ready_i | input | 1 | Controller accepts the request |
| ak_valid_i | input | 1 | Acknowledge channel valid |
| ak_kind_i | input | 2 | Acknowledge code: 00/01 data acknowledge, 10 flush demand |
| ak_ready_o | output | 1 | Agent accepts the acknowledge channel |

## Verification
The hardest case to reach is a flush demand that arrives while a data request is still waiting for its acknowledgement and data wishes stay high. Only in that case do flush priority and the acknowledge-ready rule interact. The stimulus reaches it in a directed phase. A burst request is first held unaccepted for some cycles and then accepted. A flush code follows, then a data acknowledgement with both wishes still asserted. A long random phase then mixes back-pressure, unsolicited acknowledges, reserved codes and repeated flush demands, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/pdma_req_pkg.sv
package pdma_req_pkg;

  typedef enum logic [1:0] {
    RK_SINGLE    = 2'b00,
    RK_BURST     = 2'b01,
    RK_FLUSH_ACK = 2'b10
  } rq_kind_e;

  typedef enum logic [1:0] {
    AG_IDLE = 2'b00,
    AG_REQ  = 2'b01,
    AG_WAIT = 2'b10
  } agent_st_e;

  localparam logic [1:0] AK_FLUSH_CODE = 2'b10;

endpackage

// File: rtl/pdma_issue_sel.sv
module pdma_issue_sel
  import pdma_req_pkg::*;
(
  input  logic     flush_pend_i,
  input  logic     want_single_i,
  input  logic     want_burst_i,
  input  logic     want_last_i,
  output logic     issue_o,
  output rq_kind_e kind_o,
  output logic     last_o
);

  always_comb begin
    issue_o = 1'b0;
    kind_o  = RK_SINGLE;
    last_o  = 1'b0;
    if (flush_pend_i) begin
      issue_o = 1'b1;
      kind_o  = RK_FLUSH_ACK;
    end else if (want_burst_i) begin
      issue_o = 1'b1;
      kind_o  = RK_BURST;
      last_o  = want_last_i;
    end else if (want_single_i) begin
      issue_o = 1'b1;
      kind_o  = RK_SINGLE;
      last_o  = want_last_i;
    end
  end

endmodule

// File: rtl/pdma_flush_track.sv
module pdma_flush_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = set_i | clr_i;
    pend_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  p_flush_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o)
    else $error("flush demand not recorded");

endmodule

// File: rtl/pdma_req_fsm.sv
module pdma_req_fsm
  import pdma_req_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     issue_i,
  input  rq_kind_e kind_i,
  input  logic     last_i,
  input  logic     rq_ready_i,
  input  logic     ack_done_i,
  output logic     rq_valid_o,
  output rq_kind_e rq_kind_o,
  output logic     rq_last_o,
  output logic     waiting_o,
  output logic     flush_acc_o
);

  agent_st_e st_q, st_d;
  rq_kind_e  kind_q;
  logic      last_q;
  logic      load_en;

  always_comb begin
    st_d        = st_q;
    load_en     = 1'b0;
    flush_acc_o = 1'b0;
    unique case (st_q)
      AG_IDLE: begin
        if (issue_i) begin
          st_d    = AG_REQ;
          load_en = 1'b1;
        end
      end
      AG_REQ: begin
        if (rq_ready_i) begin
          if (kind_q == RK_FLUSH_ACK) begin
            st_d        = AG_IDLE;
            flush_acc_o = 1'b1;
          end else begin
            st_d = AG_WAIT;
          end
        end
      end
      AG_WAIT: begin
        if (ack_done_i) st_d = AG_IDLE;
      end
      default: st_d = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= AG_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RK_SINGLE;
      last_q <= 1'b0;
    end else if (load_en) begin
      kind_q <= kind_i;
      last_q <= last_i;
    end
  end

  assign rq_valid_o = (st_q == AG_REQ);
  assign rq_kind_o  = kind_q;
  assign rq_last_o  = last_q;
  assign waiting_o  = (st_q == AG_WAIT);

  p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rq_valid_o) |-> $past(rq_ready_i))
    else $error("request withdrawn without acceptance");

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid_o && !rq_ready_i) |=> (rq_valid_o && $stable(rq_kind_o) && $stable(rq_last_o)))
    else $error("pending request changed");

  p_no_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid_o |-> (rq_kind_o != 2'b11))
    else $error("reserved request code presented");

  p_flush_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid_o && rq_kind_o == RK_FLUSH_ACK) |-> !rq_last_o)
    else $error("final marker set on flush acknowledge");

endmodule

// File: rtl/pdma_req_agent.sv
module pdma_req_agent
  import pdma_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pr_single_i,
  input  logic       pr_burst_i,
  input  logic       pr_last_i,
  output logic       rq_valid_o,
  output logic [1:0] rq_kind_o,
  output logic       rq_last_o,
  input  logic       rq_ready_i,
  input  logic       ak_valid_i,
  input  logic [1:0] ak_kind_i,
  output logic       ak_ready_o
);

  logic     flush_pend, issue, sel_last, waiting, flush_acc;
  logic     ak_hs, flush_set, ack_done;
  rq_kind_e sel_kind, kind_q;

  assign ak_hs     = ak_valid_i & ak_ready_o;
  assign flush_set = ak_hs & (ak_kind_i == AK_FLUSH_CODE);
  assign ack_done  = ak_hs & ~ak_kind_i[1];
  assign ak_ready_o = waiting | ~flush_pend;
  assign rq_kind_o  = kind_q;

  pdma_issue_sel u_sel (
    .flush_pend_i  (flush_pend),
    .want_single_i (pr_single_i),
    .want_burst_i  (pr_burst_i),
    .want_last_i   (pr_last_i),
    .issue_o       (issue),
    .kind_o        (sel_kind),
    .last_o        (sel_last)
  );

  pdma_flush_track u_flush (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flush_set),
    .clr_i  (flush_acc),
    .pend_o (flush_pend)
  );

  pdma_req_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue),
    .kind_i      (sel_kind),
    .last_i      (sel_last),
    .rq_ready_i  (rq_ready_i),
    .ack_done_i  (ack_done),
    .rq_valid_o  (rq_valid_o),
    .rq_kind_o   (kind_q),
    .rq_last_o   (rq_last_o),
    .waiting_o   (waiting),
    .flush_acc_o (flush_acc)
  );

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid_o && rq_ready_i && rq_kind_o != 2'b10) |=> (!rq_valid_o && !flush_acc))
    else $error("second request before acknowledgement");

  p_flush_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rq_valid_o) && $past(flush_pend)) |-> (rq_kind_o == 2'b10))
    else $error("data request issued ahead of pending flush");

endmodule

// File: tb/pdma_req_agent_tb.sv
`timescale 1ns/1ps
module pdma_req_agent_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pr_single = 1'b0, pr_burst = 1'b0, pr_last = 1'b0;
  logic       rq_ready = 1'b0, ak_valid = 1'b0;
  logic [1:0] ak_kind = 2'b00;
  logic       rq_valid, rq_last, ak_ready;
  logic [1:0] rq_kind;

  int checks = 0;
  int fails  = 0;
  bit run_chk = 0;

  // reference model state: 0 idle, 1 presenting, 2 awaiting acknowledge
  int m_st, m_kind, m_last, m_flush;
  // previous-cycle samples for rule checks
  logic p_valid = 1'b0, p_last = 1'b0, p_rr = 1'b0, rdy_seen = 1'b0;
  logic [1:0] p_kind = 2'b00;

  always #5 clk = ~clk;

  pdma_req_agent u_dut (
    .clk(clk), .rst_n(rst_n),
    .pr_single_i(pr_single), .pr_burst_i(pr_burst), .pr_last_i(pr_last),
    .rq_valid_o(rq_valid), .rq_kind_o(rq_kind), .rq_last_o(rq_last),
    .rq_ready_i(rq_ready), .ak_valid_i(ak_valid), .ak_kind_i(ak_kind),
    .ak_ready_o(ak_ready)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_kind = 0; m_last = 0; m_flush = 0;
    end else begin
      automatic int  n_st = m_st, n_kind = m_kind, n_last = m_last, n_flush = m_flush;
      automatic bit  e_rdy = (m_st == 2) || (m_flush == 0);
      automatic bit  hs = ak_valid && e_rdy;
      case (m_st)
        0: if (m_flush != 0) begin n_st = 1; n_kind = 2; n_last = 0; end
           else if (pr_burst) begin n_st = 1; n_kind = 1; n_last = pr_last; end
           else if (pr_single) begin n_st = 1; n_kind = 0; n_last = pr_last; end
        1: if (rq_ready) begin
             if (m_kind == 2) begin n_st = 0; n_flush = 0; end
             else n_st = 2;
           end
        default: if (hs && !ak_kind[1]) n_st = 0;
      endcase
      if (hs && ak_kind == 2'b10) n_flush = 1;
      m_st = n_st; m_kind = n_kind; m_last = n_last; m_flush = n_flush;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    if (!run_chk) return;
    chk(rq_valid === (m_st == 1), "R2 R6 R7 R10 valid", rq_valid, m_st == 1);
    if (m_st == 1) begin
      chk(rq_kind === 2'(m_kind), "R4 R7 R8 kind", rq_kind, m_kind);
      chk(rq_last === 1'(m_last), "R5 last", rq_last, m_last);
    end
    chk(ak_ready === ((m_st == 2) || (m_flush == 0)), "R9 ak_ready", ak_ready,
        (m_st == 2) || (m_flush == 0));
    if (p_valid && !p_rr)
      chk(rq_valid && rq_kind == p_kind && rq_last == p_last, "R3 hold",
          {rq_valid, rq_kind, rq_last}, {1'b1, p_kind, p_last});
    if (p_valid && !rq_valid) chk(p_rr, "R2 fall", p_rr, 1);
    if (rq_valid) chk(rq_kind != 2'b11, "R4 reserved", rq_kind, 0);
    if (rq_valid && rq_kind == 2'b10) chk(!rq_last, "R5 flush last", rq_last, 0);
  endtask

  task automatic tick(input logic s, b, l, rr, wa, input logic [1:0] wk);
    @(negedge clk);
    compare();
    if (!(ak_valid && !rdy_seen)) begin
      ak_valid = wa;
      ak_kind  = wk;
    end
    rdy_seen  = ak_ready;
    pr_single = s; pr_burst = b; pr_last = l; rq_ready = rr;
    p_valid = rq_valid; p_kind = rq_kind; p_last = rq_last; p_rr = rr;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rq_valid === 1'b0 && rq_kind === 2'b00 && rq_last === 1'b0 && ak_ready === 1'b1,
        "R1 reset", {rq_valid, rq_kind, rq_last, ak_ready}, 4'b0001);
    rst_n = 1'b1;
    run_chk = 1;
    // burst with final marker, held under back-pressure
    tick(0, 1, 1, 0, 0, 2'b00);
    tick(0, 1, 1, 0, 0, 2'b00);
    tick(0, 1, 1, 0, 0, 2'b00);
    tick(0, 1, 1, 1, 0, 2'b00);
    // flush demand during wait, then data acknowledge, wishes still high
    tick(1, 1, 0, 0, 1, 2'b10);
    tick(1, 1, 0, 0, 1, 2'b00);
    tick(1, 1, 0, 0, 0, 2'b00);
    tick(1, 1, 0, 0, 0, 2'b00);
    chk(rq_valid && rq_kind == 2'b10 && !rq_last, "R7 flush first",
        {rq_valid, rq_kind, rq_last}, 4'b1100);
    chk(ak_ready == 1'b0, "R9 flush pending", ak_ready, 0);
    tick(1, 1, 0, 1, 0, 2'b00);
    tick(1, 1, 0, 0, 0, 2'b00);
    tick(1, 1, 0, 0, 0, 2'b00);
    chk(rq_valid && rq_kind == 2'b01, "R8 burst over single", rq_kind, 1);
    chk(ak_ready == 1'b1, "R10 flag cleared", ak_ready, 1);
    tick(1, 0, 1, 1, 0, 2'b00);
    repeat (4) tick(1, 0, 1, 0, 0, 2'b00);
    chk(!rq_valid, "R6 no request before ack", rq_valid, 0);
    tick(1, 0, 1, 0, 1, 2'b11);
    tick(1, 0, 1, 0, 0, 2'b00);
    chk(!rq_valid, "R10 reserved ack ignored", rq_valid, 0);
    tick(1, 0, 1, 0, 1, 2'b01);
    tick(1, 0, 1, 0, 0, 2'b00);
    tick(1, 0, 1, 0, 0, 2'b00);
    chk(rq_valid && rq_kind == 2'b00 && rq_last, "R5 single last",
        {rq_valid, rq_kind, rq_last}, 4'b1001);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      automatic int k = $urandom % 8;
      automatic logic [1:0] wk = (k < 3) ? 2'b00 : (k < 5) ? 2'b01 :
                                 (k == 5) ? 2'b10 : (k == 6) ? 2'b11 : 2'b00;
      tick(1'($urandom % 3 == 0), 1'($urandom % 4 == 0), 1'($urandom),
           1'($urandom % 3 != 0), 1'($urandom % 4 == 0), wk);
    end
    tick(0, 0, 0, 1, 0, 2'b00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule